// File: doc/BRIEF.md
# Pipelined Memory Wait-State Controller

This block sits between a pipelined processor core with separate instruction and data buses and memories that need more than one cycle per access. The core puts the address and control of a transfer on its buses one cycle before the data moves. Each bus also carries a wait count for that access. On every clock edge where the core is allowed to advance, the block captures both buses. It then presents the captured copy to memory for the whole data phase of the transfer.

The block counts out the longer of the two requested wait counts. It drives one active-low wait output that freezes the core's instruction and data sides together. This output is registered on the falling clock edge, so it only changes in the low half of the clock. A copy of it is exported as a core clock-enable for debug observation. Because the core has already moved on to the next address when a stall begins, the captured copy stays frozen until the stall ends.

Top module: `memwait_ctrl`

## Requirements
- R1: While `rst_n` is low, `core_wait_n` and `dbg_core_en` are 1, and each memory-side address, request and write output follows the matching core-side input combinationally.
- R2: On each rising edge where `core_wait_n` is 1, both ports capture their address, request and write inputs. The captured values appear on the memory-side outputs after that edge, so transfers reach memory one after another in the order the core issued them.
- R3: On a rising edge where `core_wait_n` is 0, no memory-side output changes, on either port.
- R4: A transfer whose effective wait count is 0 causes no stall. `core_wait_n` stays 1 and the next transfer is captured on the following rising edge.
- R5: A port's effective wait count is its 4-bit count input if its request is 1, and 0 otherwise. A transfer captured with effective counts a and b holds `core_wait_n` at 0 for exactly max(a,b) rising edges after the capture edge.
- R6: `core_wait_n` changes only on the falling clock edge. It has the same value just after a rising edge as it had just before that edge.
- R7: `dbg_core_en` equals `core_wait_n` at all times.
- R8: The full count range works: a count of 15 gives 15 stalled edges, and a count of 1 gives exactly one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_addr | input | ADDR_W | Instruction-side address from the core |
| ins_req | input | 1 | Instruction-side request |
| ins_wr | input | 1 | Instruction-side write control |
| ins_wait_cnt | input | CNT_W | Wait cycles needed by this instruction access |
| dat_addr | input | ADDR_W | Data-side address from the core |
| dat_req | input | 1 | Data-side request |
| dat_wr | input | 1 | Data-side write control |
| dat_wait_cnt | input | CNT_W | Wait cycles needed by this data access |
| mem_ins_addr | output | ADDR_W | Held instruction address toward memory |
| mem_ins_req | output | 1 | Held instruction request toward memory |
| mem_ins_wr | output | 1 | Held instruction write control toward memory |
| mem_dat_addr | output | ADDR_W | Held data address toward memory |
| mem_dat_req | output | 1 | Held data request toward memory |
| mem_dat_wr | output | 1 | Held data write control toward memory |
| core_wait_n | output | 1 | Active-low stall to the core, changed on the falling edge |
| dbg_core_en | output | 1 | Exported core clock-enable for debug |

## Verification
The bench targets these corner cases:
- Zero-count transfers issued back to back. A controller with an off-by-one in its count would insert a stall cycle after each of them, and memory would see each address twice.
- Transfers where only one port requests but the idle port carries a large count. A design that forgets to mask the count by the request would stall for the ignored value.
- Mixed counts with 15 on one side and a smaller value on the other. Taking the wrong maximum, or letting the port hold reload during a stall, shows up as a wrong address or a shifted program order on the memory side.
- The wait output sampled on both sides of each rising edge. This catches a stall register updated on the wrong edge.

// File: rtl/memwait_pkg.sv
package memwait_pkg;

    localparam int NUM_PORTS = 2;
    localparam int PORT_INS  = 0;
    localparam int PORT_DAT  = 1;

    typedef enum logic {
        CORE_HELD = 1'b0,
        CORE_RUN  = 1'b1
    } core_phase_e;

endpackage

// File: rtl/memwait_port_hold.sv
module memwait_port_hold #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              advance,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic              in_req,
    input  logic              in_wr,
    input  logic [CNT_W-1:0]  in_cnt,
    output logic [CNT_W-1:0]  eff_cnt,
    output logic [ADDR_W-1:0] out_addr,
    output logic              out_req,
    output logic              out_wr
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              req;
        logic              wr;
    } hold_t;

    hold_t hold_d, hold_q;

    // Next state: reload only when the core is allowed to advance.
    always_comb begin
        hold_d = hold_q;
        if (advance) begin
            hold_d.addr = in_addr;
            hold_d.req  = in_req;
            hold_d.wr   = in_wr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else begin
            hold_q <= hold_d;
        end
    end

    // An idle port asks for no wait cycles.
    assign eff_cnt  = in_req ? in_cnt : '0;

    // During reset the memory side follows the core directly.
    assign out_addr = rst_n ? hold_q.addr : in_addr;
    assign out_req  = rst_n ? hold_q.req  : in_req;
    assign out_wr   = rst_n ? hold_q.wr   : in_wr;

    // R3: nothing reloads on a stalled edge.
    a_r3_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !advance |=> ($stable(hold_q.addr) && $stable(hold_q.req) && $stable(hold_q.wr)))
        else $error("a_r3_hold_stable");

endmodule

// File: rtl/memwait_counter.sv
module memwait_counter #(
    parameter int CNT_W     = 4,
    parameter int NUM_PORTS = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           advance,
    input  logic [NUM_PORTS-1:0][CNT_W-1:0] eff_cnt,
    output logic                           cnt_idle
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } ctr_t;

    ctr_t             ctr_d, ctr_q;
    logic [CNT_W-1:0] max_cnt;

    // One stall covers both ports, so the longest request wins.
    always_comb begin
        max_cnt = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (eff_cnt[p] > max_cnt) begin
                max_cnt = eff_cnt[p];
            end
        end
    end

    always_comb begin
        ctr_d = ctr_q;
        if (advance) begin
            ctr_d.cnt = max_cnt;
        end else if (ctr_q.cnt != '0) begin
            ctr_d.cnt = ctr_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctr_q <= '0;
        end else begin
            ctr_q <= ctr_d;
        end
    end

    assign cnt_idle = (ctr_q.cnt == '0);

    // R5: a pending count means the edge was stalled, so it drops by one.
    a_r5_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        (ctr_q.cnt != '0) |=> (ctr_q.cnt == $past(ctr_q.cnt) - 1'b1))
        else $error("a_r5_count_down");

endmodule

// File: rtl/memwait_stall_reg.sv
module memwait_stall_reg
    import memwait_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cnt_idle,
    output logic wait_n
);

    typedef struct packed {
        core_phase_e phase;
    } stall_t;

    stall_t stall_d, stall_q;

    always_comb begin
        stall_d       = stall_q;
        stall_d.phase = cnt_idle ? CORE_RUN : CORE_HELD;
    end

    // Falling-edge register keeps changes in the low half of the clock.
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stall_q <= '{phase: CORE_RUN};
        end else begin
            stall_q <= stall_d;
        end
    end

    assign wait_n = (stall_q.phase == CORE_RUN);

endmodule

// File: rtl/memwait_ctrl.sv
module memwait_ctrl
    import memwait_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] ins_addr,
    input  logic              ins_req,
    input  logic              ins_wr,
    input  logic [CNT_W-1:0]  ins_wait_cnt,
    input  logic [ADDR_W-1:0] dat_addr,
    input  logic              dat_req,
    input  logic              dat_wr,
    input  logic [CNT_W-1:0]  dat_wait_cnt,
    output logic [ADDR_W-1:0] mem_ins_addr,
    output logic              mem_ins_req,
    output logic              mem_ins_wr,
    output logic [ADDR_W-1:0] mem_dat_addr,
    output logic              mem_dat_req,
    output logic              mem_dat_wr,
    output logic              core_wait_n,
    output logic              dbg_core_en
);

    localparam int NP = NUM_PORTS;

    logic [NP-1:0][ADDR_W-1:0] in_addr, out_addr;
    logic [NP-1:0]             in_req, in_wr, out_req, out_wr;
    logic [NP-1:0][CNT_W-1:0]  in_cnt, eff_cnt;
    logic                      cnt_idle;
    logic                      wait_n;

    assign in_addr[PORT_INS] = ins_addr;
    assign in_req [PORT_INS] = ins_req;
    assign in_wr  [PORT_INS] = ins_wr;
    assign in_cnt [PORT_INS] = ins_wait_cnt;
    assign in_addr[PORT_DAT] = dat_addr;
    assign in_req [PORT_DAT] = dat_req;
    assign in_wr  [PORT_DAT] = dat_wr;
    assign in_cnt [PORT_DAT] = dat_wait_cnt;

    for (genvar p = 0; p < NP; p++) begin : g_port
        memwait_port_hold #(
            .ADDR_W (ADDR_W),
            .CNT_W  (CNT_W)
        ) u_hold (
            .clk      (clk),
            .rst_n    (rst_n),
            .advance  (wait_n),
            .in_addr  (in_addr[p]),
            .in_req   (in_req[p]),
            .in_wr    (in_wr[p]),
            .in_cnt   (in_cnt[p]),
            .eff_cnt  (eff_cnt[p]),
            .out_addr (out_addr[p]),
            .out_req  (out_req[p]),
            .out_wr   (out_wr[p])
        );
    end

    memwait_counter #(
        .CNT_W     (CNT_W),
        .NUM_PORTS (NP)
    ) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .advance  (wait_n),
        .eff_cnt  (eff_cnt),
        .cnt_idle (cnt_idle)
    );

    memwait_stall_reg u_stall (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt_idle (cnt_idle),
        .wait_n   (wait_n)
    );

    assign mem_ins_addr = out_addr[PORT_INS];
    assign mem_ins_req  = out_req [PORT_INS];
    assign mem_ins_wr   = out_wr  [PORT_INS];
    assign mem_dat_addr = out_addr[PORT_DAT];
    assign mem_dat_req  = out_req [PORT_DAT];
    assign mem_dat_wr   = out_wr  [PORT_DAT];
    assign core_wait_n  = wait_n;
    assign dbg_core_en  = wait_n;

    // R4: an edge the core may take always finds the counter drained.
    a_r4_run_means_idle: assert property (@(posedge clk) disable iff (!rst_n)
        core_wait_n |-> cnt_idle)
        else $error("a_r4_run_means_idle");

    // R5: a stalled edge always has wait cycles left to count.
    a_r5_stall_has_count: assert property (@(posedge clk) disable iff (!rst_n)
        !core_wait_n |-> !cnt_idle)
        else $error("a_r5_stall_has_count");

endmodule

// File: tb/memwait_ctrl_tb_top.sv
module memwait_ctrl_tb_top;

    localparam int PERIOD = 10;
    localparam int AW     = 32;
    localparam int CW     = 4;
    localparam int NT     = 300;

    typedef struct packed {
        logic [AW-1:0] ia;
        logic          ir;
        logic          iw;
        logic [CW-1:0] ic;
        logic [AW-1:0] da;
        logic          dr;
        logic          dw;
        logic [CW-1:0] dc;
    } xfer_t;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] ins_addr, dat_addr, mem_ins_addr, mem_dat_addr;
    logic          ins_req, ins_wr, dat_req, dat_wr;
    logic [CW-1:0] ins_wait_cnt, dat_wait_cnt;
    logic          mem_ins_req, mem_ins_wr, mem_dat_req, mem_dat_wr;
    logic          core_wait_n, dbg_core_en;

    int    checks   = 0;
    int    failures = 0;
    bit    done     = 1'b0;
    xfer_t tr [NT];

    always #(PERIOD/2) clk = ~clk;

    memwait_ctrl #(.ADDR_W(AW), .CNT_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .ins_addr(ins_addr), .ins_req(ins_req), .ins_wr(ins_wr), .ins_wait_cnt(ins_wait_cnt),
        .dat_addr(dat_addr), .dat_req(dat_req), .dat_wr(dat_wr), .dat_wait_cnt(dat_wait_cnt),
        .mem_ins_addr(mem_ins_addr), .mem_ins_req(mem_ins_req), .mem_ins_wr(mem_ins_wr),
        .mem_dat_addr(mem_dat_addr), .mem_dat_req(mem_dat_req), .mem_dat_wr(mem_dat_wr),
        .core_wait_n(core_wait_n), .dbg_core_en(dbg_core_en)
    );

    // Expected number of stalled edges: R5 masking and maximum.
    function automatic int stall_len(xfer_t t);
        int a, b;
        a = t.ir ? int'(t.ic) : 0;
        b = t.dr ? int'(t.dc) : 0;
        return (a > b) ? a : b;
    endfunction

    task automatic check(string req, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(xfer_t t);
        ins_addr = t.ia; ins_req = t.ir; ins_wr = t.iw; ins_wait_cnt = t.ic;
        dat_addr = t.da; dat_req = t.dr; dat_wr = t.dw; dat_wait_cnt = t.dc;
    endtask

    function automatic logic [127:0] mem_view();
        return {mem_ins_addr, mem_ins_req, mem_ins_wr, mem_dat_addr, mem_dat_req, mem_dat_wr};
    endfunction

    function automatic logic [127:0] tr_view(xfer_t t);
        return {t.ia, t.ir, t.iw, t.da, t.dr, t.dw};
    endfunction

    task automatic summary();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        #(PERIOD * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        int          cur;
        int          j;
        logic        prev_w;
        logic        ew;
        int unsigned seed_sink;
        xfer_t       idle_t;

        seed_sink = $urandom(32'h5EED_0042);
        idle_t    = '0;

        // Directed corner transfers first, then weighted random ones.
        tr[0] = '{ia:32'h100, ir:1, iw:0, ic:0, da:32'h200, dr:1, dw:1, dc:0};   // R4
        tr[1] = '{ia:32'h104, ir:1, iw:0, ic:0, da:32'h204, dr:1, dw:0, dc:0};   // R4 back to back
        tr[2] = '{ia:32'h108, ir:1, iw:0, ic:15, da:32'h208, dr:1, dw:1, dc:3};  // R8 max
        tr[3] = '{ia:32'h10C, ir:1, iw:0, ic:1, da:32'h20C, dr:0, dw:0, dc:0};   // R8 one
        tr[4] = '{ia:32'h110, ir:0, iw:0, ic:9, da:32'h210, dr:1, dw:1, dc:2};   // R5 mask
        tr[5] = '{ia:32'h114, ir:0, iw:1, ic:7, da:32'h214, dr:0, dw:1, dc:12};  // R5 both idle
        tr[6] = '{ia:32'h118, ir:1, iw:0, ic:4, da:32'h218, dr:1, dw:0, dc:11};  // R5 data longer
        for (int k = 7; k < NT; k++) begin
            tr[k].ia = $urandom;
            tr[k].da = $urandom;
            tr[k].ir = ($urandom % 5) != 0;
            tr[k].dr = ($urandom % 3) != 0;
            tr[k].iw = $urandom % 2;
            tr[k].dw = $urandom % 2;
            tr[k].ic = (($urandom % 8) == 0) ? 4'($urandom) : 4'($urandom % 3);
            tr[k].dc = (($urandom % 8) == 0) ? 4'($urandom) : 4'($urandom % 3);
        end

        // R1: reset state and pass-through for two input patterns.
        rst_n = 1'b0;
        drive(tr[5]);
        #(PERIOD + 3);
        check("R1 wait_n", 128'(core_wait_n), 128'(1));
        check("R1 dbg_en", 128'(dbg_core_en), 128'(1));
        check("R1 pass", mem_view(), tr_view(tr[5]));
        drive(tr[2]);
        #1;
        check("R1 pass2", mem_view(), tr_view(tr[2]));
        drive(tr[0]);

        @(negedge clk);
        #2 rst_n = 1'b1;

        @(posedge clk);          // captures tr[0]
        #1 drive(tr[1]);
        cur    = 0;
        j      = 0;
        prev_w = 1'b1;

        while (cur < NT) begin
            #1;                  // rising edge + 2
            if (j == 0) check("R2 order", mem_view(), tr_view(tr[cur]));
            else        check("R3 hold", mem_view(), tr_view(tr[cur]));
            check("R6 edge", 128'(core_wait_n), 128'(prev_w));
            #5;                  // rising edge + 7, past the falling edge
            ew = (j == stall_len(tr[cur]));
            check(stall_len(tr[cur]) == 0 ? "R4 no stall" : "R5 stall len",
                  128'(core_wait_n), 128'(ew));
            check("R7 dbg", 128'(dbg_core_en), 128'(core_wait_n));
            prev_w = core_wait_n;
            @(posedge clk);
            if (prev_w) begin
                cur++;
                j = 0;
                #1 drive((cur + 1 < NT) ? tr[cur + 1] : idle_t);
            end else begin
                #1;
                j++;
            end
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule